// File: doc/BRIEF.md
# Two-Wire Bus Input Conditioner

This block sits between the two open-drain pins of a two-wire serial bus (clock line and data line) and the protocol engine of a slave device. It samples both pins with a fast system clock, passes each one through a synchronizer and a spike filter, and turns the cleaned levels into single-cycle events: clock rising, clock falling, START and STOP. It also reports whether the bus is free.

On the transmit side it decides when the slave's data-line pull-down may change. The protocol engine raises or drops a request at any time. The block registers that request. It then applies the request only while the filtered clock is low, and only after a hold window has run out since the last clock falling edge. As a result, driven data never moves close to the clock falling edge, and the slave can never create a false START or STOP.

All timing is set by nanosecond parameters: the clock period, the longest spike to reject and the minimum output hold. The block turns these into cycle counts when it elaborates.

Top module: `twb_input_cond`

## Requirements
- R1: After reset, `scl_o` and `sda_o` are 1, `bus_free` is 1, `sda_oe` is 0, and no event output is high.
- R2: A pin pulse that spans fewer than FILT_CYCLES = ceil(SPIKE_NS/CLK_PERIOD_NS)+1 clock samples is rejected. At the defaults this is a pulse of up to 60 ns, which covers every 50 ns spike. A rejected pulse leaves the filtered line unchanged and produces no event. A level held for FILT_CYCLES samples (80 ns at the defaults) is accepted.
- R3: When the filtered data line falls while the filtered clock stays high, `start_det` is high for exactly one cycle.
- R4: When the filtered data line rises while the filtered clock stays high, `stop_det` is high for exactly one cycle.
- R5: Each filtered clock transition produces exactly one single-cycle pulse: `scl_rise` for a rise and `scl_fall` for a fall. The two pulses are never high in the same cycle.
- R6: In the cycle where `scl_rise` is high, `sda_o` carries the bit that was driven during the preceding clock-low phase. Data-line changes while the clock is low never produce START or STOP.
- R7: `bus_free` goes to 0 in the cycle after `start_det` and goes to 1 in the cycle after `stop_det`. A repeated START keeps it at 0.
- R8: `sda_oe` changes only while the filtered clock is low, and only when at least HOLD_CYCLES+1 cycles have passed since the `scl_fall` cycle. HOLD_CYCLES = ceil(HOLD_NS/CLK_PERIOD_NS), which is 15 at the defaults. When a request is already pending at the fall, `sda_oe` takes its new value exactly HOLD_CYCLES+2 cycles after the `scl_fall` cycle.
- R9: `sda_oe_req` is registered. When the clock is low and the hold window has expired, `sda_oe` follows a change of the request two cycles later. A request made while the clock is high waits for the next fall and hold window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw clock-line pin level (asynchronous) |
| sda_i | input | 1 | Raw data-line pin level (asynchronous) |
| sda_oe_req | input | 1 | Protocol engine request to pull the data line low |
| scl_o | output | 1 | Filtered clock-line level |
| sda_o | output | 1 | Filtered data-line level |
| scl_rise | output | 1 | One-cycle pulse on a filtered clock rise |
| scl_fall | output | 1 | One-cycle pulse on a filtered clock fall |
| start_det | output | 1 | One-cycle pulse on a START condition |
| stop_det | output | 1 | One-cycle pulse on a STOP condition |
| bus_free | output | 1 | High from STOP (or reset) until the next START |
| sda_oe | output | 1 | Data-line pull-down enable for the pad |

## Verification
The assertions on conditions and data stability assume the raw pins only ever differ from a settled level by rejected spikes or by real transitions. They also assume the data pin is moved while the clock pin is low, except where the stimulus intends a START or STOP. The hold-window property assumes a clock low phase longer than the hold window plus the filter latency. The stimulus keeps to these assumptions in three ways. It changes pins only at falling system-clock edges or at offsets that avoid rising edges. It limits random glitches to widths of 20 or 40 ns. It keeps every clock phase at least ten system cycles long.

// File: rtl/twb_pkg.sv
`timescale 1ns/1ps
package twb_pkg;

    localparam int NUM_LINES = 2;
    localparam int IDX_SCL   = 0;
    localparam int IDX_SDA   = 1;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } twb_evt_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/twb_glitch_filter.sv
`timescale 1ns/1ps
// Synchronizer chain followed by a persistence filter: the output level
// follows the synchronized input only after it has differed for
// FILT_CYCLES consecutive samples.
module twb_glitch_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_CYCLES = 4,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] RUN_LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          run;
        logic                   level;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       synced;

    assign synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        if (synced == st_q.level) begin
            st_d.run = '0;
        end else if (st_q.run == RUN_LAST) begin
            st_d.level = synced;
            st_d.run   = '0;
        end else begin
            st_d.run = st_q.run + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sync  <= {SYNC_STAGES{IDLE_LEVEL}};
            st_q.run   <= '0;
            st_q.level <= IDLE_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/twb_cond_detect.sv
`timescale 1ns/1ps
// Edge, START/STOP and bus-free tracking on the filtered line levels.
module twb_cond_detect
    import twb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output twb_evt_t evt_o,
    output logic     bus_free_o
);

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic free;
    } det_state_t;

    det_state_t st_d, st_q;
    twb_evt_t   evt;

    always_comb begin
        evt.scl_rise = scl_i & ~st_q.scl_prev;
        evt.scl_fall = ~scl_i & st_q.scl_prev;
        // clock held high across the cycle, data moved
        evt.start    = scl_i & st_q.scl_prev & st_q.sda_prev & ~sda_i;
        evt.stop     = scl_i & st_q.scl_prev & ~st_q.sda_prev & sda_i;

        st_d          = st_q;
        st_d.scl_prev = scl_i;
        st_d.sda_prev = sda_i;
        if (evt.start) begin
            st_d.free = 1'b0;
        end else if (evt.stop) begin
            st_d.free = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.scl_prev <= 1'b1;
            st_q.sda_prev <= 1'b1;
            st_q.free     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o      = evt;
    assign bus_free_o = st_q.free;

endmodule

// File: rtl/twb_oe_hold.sv
`timescale 1ns/1ps
// Gates the data-line pull-down: the registered request is applied only
// while the clock is low and the post-fall hold counter has run out.
module twb_oe_hold #(
    parameter int HOLD_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_level_i,
    input  logic scl_fall_i,
    input  logic oe_req_i,
    output logic oe_o
);

    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYCLES);

    typedef struct packed {
        logic          req;
        logic [HW-1:0] cnt;
        logic          oe;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        may_update;

    always_comb begin
        st_d     = st_q;
        st_d.req = oe_req_i;

        if (scl_fall_i) begin
            st_d.cnt = HOLD_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - HW'(1);
        end

        may_update = !scl_fall_i && !scl_level_i && (st_q.cnt == '0);
        if (may_update) begin
            st_d.oe = st_q.req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.req <= 1'b0;
            st_q.cnt <= '0;
            st_q.oe  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o = st_q.oe;

endmodule

// File: rtl/twb_input_cond.sv
`timescale 1ns/1ps
module twb_input_cond
    import twb_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPIKE_NS      = 50,
    parameter int HOLD_NS       = 300,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sda_oe_req,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_free,
    output logic sda_oe
);

    localparam int FILT_CYCLES = ceil_div(SPIKE_NS, CLK_PERIOD_NS) + 1;
    localparam int HOLD_CYCLES = ceil_div(HOLD_NS, CLK_PERIOD_NS);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] flt_lines;
    twb_evt_t             evt;

    assign raw_lines[IDX_SCL] = scl_i;
    assign raw_lines[IDX_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        twb_glitch_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYCLES (FILT_CYCLES),
            .IDLE_LEVEL  (1'b1)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (raw_lines[g]),
            .level_o (flt_lines[g])
        );
    end

    twb_cond_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (flt_lines[IDX_SCL]),
        .sda_i      (flt_lines[IDX_SDA]),
        .evt_o      (evt),
        .bus_free_o (bus_free)
    );

    twb_oe_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_level_i (flt_lines[IDX_SCL]),
        .scl_fall_i  (evt.scl_fall),
        .oe_req_i    (sda_oe_req),
        .oe_o        (sda_oe)
    );

    assign scl_o     = flt_lines[IDX_SCL];
    assign sda_o     = flt_lines[IDX_SDA];
    assign scl_rise  = evt.scl_rise;
    assign scl_fall  = evt.scl_fall;
    assign start_det = evt.start;
    assign stop_det  = evt.stop;

endmodule

// File: rtl/twb_input_cond_chk.sv
`timescale 1ns/1ps
module twb_input_cond_chk #(
    parameter int HOLD_CYCLES = 15
) (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic sda_o,
    input logic scl_rise,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic bus_free,
    input logic sda_oe
);

    localparam logic [31:0] SINCE_SAT = 32'(HOLD_CYCLES + 1);

    // cycles elapsed since the last filtered clock fall, saturating
    logic [31:0] since_fall_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fall_q <= SINCE_SAT;
        end else if (scl_fall) begin
            since_fall_q <= '0;
        end else if (since_fall_q < SINCE_SAT) begin
            since_fall_q <= since_fall_q + 32'd1;
        end
    end

    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);

    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> (start_det || stop_det));

    // R7
    free_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_free);

    // R7
    free_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> bus_free);

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_o));

    // R8
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (since_fall_q > 32'(HOLD_CYCLES)));

endmodule

bind twb_input_cond twb_input_cond_chk #(
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bus_free  (bus_free),
    .sda_oe    (sda_oe)
);

// File: tb/twb_input_cond_tb.sv
`timescale 1ns/1ps
module twb_input_cond_tb;

    localparam int CLK_NS = 20;
    localparam int HOLD_C = (300 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_pin = 1'b1;
    logic sda_pin = 1'b1;
    logic oe_req = 1'b0;
    logic scl_o, sda_o, scl_rise, scl_fall, start_det, stop_det, bus_free, sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
    logic bit_log [0:511];
    int bit_cnt = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    twb_input_cond u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_pin), .sda_i(sda_pin),
        .sda_oe_req(oe_req), .scl_o(scl_o), .sda_o(sda_o),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .bus_free(bus_free), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_det) n_start++;
            if (stop_det)  n_stop++;
            if (scl_fall)  n_fall++;
            if (scl_rise) begin
                n_rise++;
                if (bit_cnt < 512) bit_log[bit_cnt] = sda_o;
                bit_cnt++;
            end
        end
    end

    function automatic logic exp_bit(input logic [7:0] b, input int idx);
        return b[7-idx];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic glitch(input bit on_sda, input int off_ns, input int width_ns);
        @(negedge clk);
        #(off_ns);
        if (on_sda) sda_pin = ~sda_pin; else scl_pin = ~scl_pin;
        #(width_ns);
        if (on_sda) sda_pin = ~sda_pin; else scl_pin = ~scl_pin;
        @(negedge clk);
        wait_cyc(8);
    endtask

    task automatic bit_xfer(input logic b);
        if ($urandom_range(3, 0) == 0) begin
            glitch(1'b0, $urandom_range(9, 1), 20 * $urandom_range(2, 1));
        end else begin
            wait_cyc(5);
        end
        sda_pin = b;
        wait_cyc(5);
        scl_pin = 1'b1;
        wait_cyc(10);
        scl_pin = 1'b0;
    endtask

    task automatic do_start;
        sda_pin = 1'b1; wait_cyc(5);
        scl_pin = 1'b1; wait_cyc(10);
        sda_pin = 1'b0; wait_cyc(10);
        scl_pin = 1'b0; wait_cyc(5);
    endtask

    task automatic do_stop;
        sda_pin = 1'b0; wait_cyc(5);
        scl_pin = 1'b1; wait_cyc(10);
        sda_pin = 1'b1; wait_cyc(10);
    endtask

    task automatic wait_fall;
        int guard;
        guard = 0;
        @(negedge clk);
        while (!scl_fall && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk("R5", "scl_fall seen", int'(scl_fall), 1);
    endtask

    initial begin
        int s0, r0, f0, b0;
        logic [7:0] byt;
        void'($urandom(32'd1357));

        // R1: state during and right after reset
        wait_cyc(4);
        chk("R1", "scl_o in reset", int'(scl_o), 1);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1", "sda_o", int'(sda_o), 1);
        chk("R1", "bus_free", int'(bus_free), 1);
        chk("R1", "sda_oe", int'(sda_oe), 0);
        chk("R1", "events", int'({scl_rise, scl_fall, start_det, stop_det}), 0);

        // R2: random short glitches on both lines while idle
        for (int i = 0; i < 12; i++) begin
            glitch(i[0], $urandom_range(9, 1), 20 * $urandom_range(2, 1));
        end
        glitch(1'b1, 2, 50);
        glitch(1'b0, 2, 50);
        glitch(1'b0, 1, 60);
        chk("R2", "rises after glitches", n_rise, 0);
        chk("R2", "falls after glitches", n_fall, 0);
        chk("R2", "start/stop after glitches", n_start + n_stop, 0);
        chk("R2", "bus_free after glitches", int'(bus_free), 1);

        // R2/R5: a low pulse spanning FILT_CYCLES samples is accepted
        glitch(1'b0, 1, 80);
        chk("R2", "80ns pulse fall", n_fall, 1);
        chk("R5", "80ns pulse rise", n_rise, 1);
        chk("R2", "80ns pulse no condition", n_start + n_stop, 0);

        // R3/R7: START
        do_start;
        wait_cyc(4);
        chk("R3", "start count", n_start, 1);
        chk("R7", "bus_free after start", int'(bus_free), 0);

        // R6/R5: random bytes
        for (int k = 0; k < 6; k++) begin
            byt = 8'($urandom);
            if (k == 0) byt = 8'h00;
            if (k == 1) byt = 8'hFF;
            b0 = bit_cnt;
            s0 = n_start + n_stop;
            for (int j = 0; j < 8; j++) bit_xfer(exp_bit(byt, j));
            wait_cyc(10);
            chk("R5", "rises per byte", bit_cnt - b0, 8);
            for (int j = 0; j < 8; j++) begin
                chk("R6", "sampled bit", int'(bit_log[b0 + j]), int'(exp_bit(byt, j)));
            end
            chk("R6", "no condition in byte", n_start + n_stop, s0);
        end

        // R7: repeated START keeps the bus busy
        do_start;
        wait_cyc(4);
        chk("R7", "repeated start count", n_start, 2);
        chk("R7", "bus_free after repeated start", int'(bus_free), 0);

        // R9: request raised while the clock is high waits for the fall
        scl_pin = 1'b1;
        wait_cyc(10);
        oe_req = 1'b1;
        wait_cyc(10);
        chk("R9", "oe held while scl high", int'(sda_oe), 0);
        scl_pin = 1'b0;
        wait_fall;
        wait_cyc(HOLD_C + 1);
        chk("R8", "oe before hold end", int'(sda_oe), 0);
        wait_cyc(1);
        chk("R8", "oe at hold end", int'(sda_oe), 1);

        // R8: release request right at the fall
        scl_pin = 1'b1;
        wait_cyc(10);
        chk("R8", "oe kept while scl high", int'(sda_oe), 1);
        scl_pin = 1'b0;
        wait_fall;
        oe_req = 1'b0;
        wait_cyc(HOLD_C + 1);
        chk("R8", "oe release before hold end", int'(sda_oe), 1);
        wait_cyc(1);
        chk("R8", "oe release at hold end", int'(sda_oe), 0);

        // R9: hold expired, clock low: two-cycle follow
        wait_cyc(25);
        oe_req = 1'b1;
        wait_cyc(1);
        chk("R9", "oe one cycle after request", int'(sda_oe), 0);
        wait_cyc(1);
        chk("R9", "oe two cycles after request", int'(sda_oe), 1);
        oe_req = 1'b0;
        wait_cyc(4);

        // R4/R7: STOP
        r0 = n_stop;
        f0 = n_start;
        do_stop;
        wait_cyc(4);
        chk("R4", "stop count", n_stop, r0 + 1);
        chk("R4", "no start at stop", n_start, f0);
        chk("R7", "bus_free after stop", int'(bus_free), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule